// File: doc/BRIEF.md
# Multi-Bank Flash Command Sequencer

This block sits between a host write port and a four-bank flash-style array. It decodes streams of host write cycles into word-program and erase operations, tracks which banks hold an operation in progress, and tells the read path, for any read address, whether array data may be returned or a status word must be returned instead. A bank that is neither programming nor erasing can be read with no extra latency while another bank works.

Programs are started by a three-write unlock prefix followed by the target write. A shortened two-write program form is available once a bypass mode is entered by command or forced by an accelerate input. Erase covers a single sector, a list of sectors gathered within a time window, or the whole array. A running erase can be suspended: the erasing banks then stop reporting busy, and reads and programs are allowed in them except inside the sectors being erased. A `op_done` pulse stands in for the array finishing its current operation.

Top module: `mbcs_top`

## Requirements
- R1: After reset all `bank_busy` bits are 0, `bypass_on` and `erase_susp` are 0, and `rd_array_ok` is 1 for every address.
- R2: The writes 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then any data at address X (unlock addresses compare the low 11 bits) start a program in bank X[11:10]: from the edge of the last write only that `bank_busy` bit is set, and `rd_array_ok` is 0 for that bank and 1 for others.
- R3: A write that does not match the next expected unlock step returns the decoder to read mode, so the rest of the intended sequence starts nothing.
- R4: The unlock prefix with 0x20 at 0x555 as third write sets `bypass_on`; in bypass mode 0xA0 at any address followed by data at X starts a program in bank X[11:10].
- R5: In bypass mode the writes 0x90 then 0x00 (any address) clear `bypass_on`; afterwards the two-write program form starts nothing.
- R6: While `accel` is 1, `bypass_on` is 1 and the exit pair has no effect; bypass mode persists after `accel` falls until the exit pair.
- R7: `op_done` ends the running program and clears its busy bit; a program aimed at a busy bank, or issued while a program runs, is ignored.
- R8: The unlock prefix, 0x80 at 0x555, the unlock prefix again, then 0x30 at a sector address begins collecting sectors; every further 0x30 write adds its sector and restarts a window of COLL_CYC idle cycles. The erase starts when the window expires or on any other write, and then the banks holding listed sectors are busy.
- R9: 0x10 at 0x555 as the sixth erase write marks every sector and makes all four banks busy.
- R10: A 0xB0 write during a running erase suspends it: `erase_susp` is 1, the erasing banks are no longer busy, reads and programs inside a listed sector are refused and elsewhere are allowed.
- R11: A 0x30 write while suspended and with no program running resumes the erase (its banks busy again, `erase_susp` 0); a later `op_done` ends it.
- R12: Sectors are 256 words, except that the lowest 256 words of bank 0 and the highest 256 words of bank 3 are each split into four 64-word boot sectors.
- R13: An erase sequence is refused at its 0x80 write when any program or erase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write cycle valid |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | 8 | Host write command or data byte |
| accel | input | 1 | Forces bypass program mode while high |
| op_done | input | 1 | Array finished the current operation |
| rd_addr | input | ADDR_W | Address of the read being arbitrated |
| bank_busy | output | 4 | Per-bank busy flags |
| rd_array_ok | output | 1 | 1: read returns array data, 0: status word |
| bypass_on | output | 1 | Two-write program mode active |
| erase_susp | output | 1 | An erase is suspended |

## Verification
The assertions take for granted that `op_done` is only pulsed while an operation is running or is harmless otherwise, that `accel` changes only between cycles, and that reset is applied before the first edge. The stimulus keeps to these by pulsing `op_done` for one cycle, driving every input away from the active edge, and holding reset low from time zero. The random phase mixes programs to arbitrary addresses and completion pulses while an erase is suspended, so programs inside and outside listed sectors and to busy and idle banks all occur.

// File: rtl/mbcs_pkg.sv
// Shared constants and the decoder state type for the command sequencer.
// Assumes a fixed four-bank array and byte-wide command codes.
package mbcs_pkg;
    localparam int NBANK     = 4;
    localparam int BANK_BITS = 2;
    localparam int UNLK_BITS = 11;

    localparam logic [7:0] CMD_UNLK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLK2 = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_BYP   = 8'h20;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_SUSP  = 8'hB0;
    localparam logic [7:0] CMD_BPX1  = 8'h90;
    localparam logic [7:0] CMD_BPX2  = 8'h00;

    localparam logic [UNLK_BITS-1:0] ADR_KEY1 = 11'h555;
    localparam logic [UNLK_BITS-1:0] ADR_KEY2 = 11'h2AA;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_BPPGM, SQ_BPX,
        SQ_E1, SQ_E2, SQ_E3, SQ_COLL
    } seq_state_t;
endpackage

// File: rtl/mbcs_secdec.sv
// Sector decoder: maps a word address to its bank and a sector index
// {bank, slot}. Large sectors use slots 0..BIG_PER-1, boot sectors use
// slots BIG_PER.. in the bottom large sector of bank 0 and the top one of
// the last bank. Assumes SEC_W > BOOT_W and ADDR_W-2 > SEC_W.
module mbcs_secdec #(
    parameter int ADDR_W = 12,
    parameter int SEC_W  = 8,
    parameter int BOOT_W = 6,
    localparam int BANK_AW  = ADDR_W - mbcs_pkg::BANK_BITS,
    localparam int BIG_W    = BANK_AW - SEC_W,
    localparam int BIG_PER  = 1 << BIG_W,
    localparam int BOOT_PER = 1 << (SEC_W - BOOT_W),
    localparam int SLOT_W   = $clog2(BIG_PER + BOOT_PER),
    localparam int IDX_W    = SLOT_W + mbcs_pkg::BANK_BITS
) (
    input  logic [ADDR_W-1:0]                 addr,
    output logic [mbcs_pkg::BANK_BITS-1:0]    bank,
    output logic [IDX_W-1:0]                  idx
);
    logic [BANK_AW-1:0] off;
    logic [BIG_W-1:0]   big;
    logic               boot;
    logic [SLOT_W-1:0]  slot;

    // Split the address into bank, large-sector number and boot flag.
    always_comb begin
        bank = addr[ADDR_W-1 -: mbcs_pkg::BANK_BITS];
        off  = addr[BANK_AW-1:0];
        big  = off[BANK_AW-1:SEC_W];
        boot = (bank == '0 && big == '0) || (bank == '1 && big == '1);
        slot = boot ? SLOT_W'(BIG_PER) + SLOT_W'(off[SEC_W-1:BOOT_W])
                    : SLOT_W'(big);
        idx  = {bank, slot};
    end
endmodule

// File: rtl/mbcs_seq.sv
// Write-cycle decoder: walks the unlock, program, bypass, erase and
// suspend/resume sequences and emits one-cycle request pulses. Holds the
// bypass mode flag and the sector collection window counter.
// Assumes the tracker accepts or refuses requests on its own rules.
module mbcs_seq #(
    parameter int ADDR_W   = 12,
    parameter int COLL_CYC = 16,
    localparam int CNT_W   = $clog2(COLL_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              accel,
    input  logic              ops_idle,
    output logic              pg_req,
    output logic              er_add,
    output logic              er_go,
    output logic              er_chip,
    output logic              sus_req,
    output logic              res_req,
    output logic              bypass_on
);
    import mbcs_pkg::*;

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             byp_q, byp_set, byp_clr;
    logic             at_k1, at_k2, hit1, hit2;

    assign bypass_on = byp_q | accel;

    // Unlock step matching on the low address bits.
    always_comb begin
        at_k1 = wr_addr[UNLK_BITS-1:0] == ADR_KEY1;
        at_k2 = wr_addr[UNLK_BITS-1:0] == ADR_KEY2;
        hit1  = at_k1 && wr_data == CMD_UNLK1;
        hit2  = at_k2 && wr_data == CMD_UNLK2;
    end

    // Next-state decode and request pulse generation.
    always_comb begin
        st_d = st_q;     cnt_d = cnt_q;
        pg_req = 1'b0;   er_add = 1'b0;  er_go = 1'b0;  er_chip = 1'b0;
        sus_req = 1'b0;  res_req = 1'b0; byp_set = 1'b0; byp_clr = 1'b0;
        case (st_q)
            SQ_IDLE: if (wr_en) begin
                if (bypass_on && wr_data == CMD_PROG)       st_d = SQ_BPPGM;
                else if (bypass_on && wr_data == CMD_BPX1)  st_d = SQ_BPX;
                else if (!bypass_on && hit1)                st_d = SQ_U1;
                else if (wr_data == CMD_SUSP)               sus_req = 1'b1;
                else if (wr_data == CMD_SECT)               res_req = 1'b1;
            end
            SQ_U1: if (wr_en) st_d = hit2 ? SQ_U2 : SQ_IDLE;
            SQ_U2: if (wr_en) begin
                st_d = SQ_IDLE;
                if (at_k1 && wr_data == CMD_PROG)                   st_d = SQ_PGM;
                else if (at_k1 && wr_data == CMD_BYP)               byp_set = 1'b1;
                else if (at_k1 && wr_data == CMD_ERASE && ops_idle) st_d = SQ_E1;
            end
            SQ_PGM, SQ_BPPGM: if (wr_en) begin
                pg_req = 1'b1;
                st_d   = SQ_IDLE;
            end
            SQ_BPX: if (wr_en) begin
                byp_clr = wr_data == CMD_BPX2;
                st_d    = SQ_IDLE;
            end
            SQ_E1: if (wr_en) st_d = hit1 ? SQ_E2 : SQ_IDLE;
            SQ_E2: if (wr_en) st_d = hit2 ? SQ_E3 : SQ_IDLE;
            SQ_E3: if (wr_en) begin
                st_d = SQ_IDLE;
                if (at_k1 && wr_data == CMD_CHIP) begin
                    er_chip = 1'b1;
                end else if (wr_data == CMD_SECT) begin
                    er_add = 1'b1;
                    cnt_d  = '0;
                    st_d   = SQ_COLL;
                end
            end
            SQ_COLL: begin
                if (wr_en) begin
                    if (wr_data == CMD_SECT) begin
                        er_add = 1'b1;
                        cnt_d  = '0;
                    end else begin
                        er_go = 1'b1;
                        st_d  = SQ_IDLE;
                    end
                end else if (cnt_q == CNT_W'(COLL_CYC - 1)) begin
                    er_go = 1'b1;
                    st_d  = SQ_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // State, window counter and bypass flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            byp_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            byp_q <= accel | byp_set | (byp_q & ~byp_clr);
        end
    end
endmodule

// File: rtl/mbcs_track.sv
// Operation tracker: holds the running program (one at a time), the
// running erase with its sector map, the suspend flag and the staging map
// filled during sector collection. Decides acceptance of requests and
// derives per-bank busy. Assumes at most one request pulse per cycle.
module mbcs_track #(
    parameter int IDX_W  = 5,
    localparam int MAP_N = 1 << IDX_W,
    localparam int SLOTS = MAP_N / mbcs_pkg::NBANK
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pg_req,
    input  logic [mbcs_pkg::BANK_BITS-1:0] wr_bank,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic                           er_add,
    input  logic                           er_go,
    input  logic                           er_chip,
    input  logic                           sus_req,
    input  logic                           res_req,
    input  logic                           op_done,
    output logic [mbcs_pkg::NBANK-1:0]     bank_busy,
    output logic [MAP_N-1:0]               er_map,
    output logic                           er_susp,
    output logic                           ops_idle
);
    import mbcs_pkg::*;

    logic                 prog_on, er_on;
    logic [BANK_BITS-1:0] prog_bank;
    logic [MAP_N-1:0]     stage;
    logic [NBANK-1:0]     er_banks;
    logic                 pg_ok, er_start;

    // Per-bank busy from the program owner and the erase map.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign er_banks[b]  = |er_map[b*SLOTS +: SLOTS];
        assign bank_busy[b] = (prog_on && prog_bank == BANK_BITS'(b)) ||
                              (er_on && !er_susp && er_banks[b]);
    end

    // Acceptance rules for new programs and erases.
    always_comb begin
        ops_idle = !prog_on && !er_on;
        pg_ok    = pg_req && !prog_on && !bank_busy[wr_bank] &&
                   !(er_on && er_susp && er_map[wr_idx]);
        er_start = (er_go || er_chip) && ops_idle;
    end

    // Program owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_on   <= 1'b0;
            prog_bank <= '0;
        end else if (pg_ok) begin
            prog_on   <= 1'b1;
            prog_bank <= wr_bank;
        end else if (op_done && prog_on) begin
            prog_on   <= 1'b0;
        end
    end

    // Erase map, staging map and suspend state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            er_on   <= 1'b0;
            er_map  <= '0;
            stage   <= '0;
            er_susp <= 1'b0;
        end else begin
            if (er_start) begin
                er_on  <= 1'b1;
                er_map <= er_chip ? '1 : stage;
                stage  <= '0;
            end else begin
                if (er_add) stage[wr_idx] <= 1'b1;
                if (op_done && !prog_on && er_on && !er_susp) begin
                    er_on  <= 1'b0;
                    er_map <= '0;
                end
            end
            if (sus_req && er_on && !er_susp)
                er_susp <= 1'b1;
            else if (res_req && er_susp && !prog_on)
                er_susp <= 1'b0;
        end
    end
endmodule

// File: rtl/mbcs_top.sv
// Multi-bank command sequencer top: decodes host writes, tracks bank
// activity and arbitrates reads. A read gets array data unless its bank
// is busy or it falls in a sector of a suspended erase.
module mbcs_top #(
    parameter int ADDR_W   = 12,
    parameter int SEC_W    = 8,
    parameter int BOOT_W   = 6,
    parameter int COLL_CYC = 16,
    localparam int BIG_PER = 1 << (ADDR_W - mbcs_pkg::BANK_BITS - SEC_W),
    localparam int IDX_W   = $clog2(BIG_PER + (1 << (SEC_W - BOOT_W)))
                             + mbcs_pkg::BANK_BITS,
    localparam int MAP_N   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              accel,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [3:0]        bank_busy,
    output logic              rd_array_ok,
    output logic              bypass_on,
    output logic              erase_susp
);
    logic [1:0]       wr_bank, rd_bank;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             pg_req, er_add, er_go, er_chip, sus_req, res_req;
    logic             ops_idle;
    logic [MAP_N-1:0] er_map;

    mbcs_secdec #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BOOT_W(BOOT_W)) i_wdec (
        .addr(wr_addr), .bank(wr_bank), .idx(wr_idx));

    mbcs_secdec #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BOOT_W(BOOT_W)) i_rdec (
        .addr(rd_addr), .bank(rd_bank), .idx(rd_idx));

    mbcs_seq #(.ADDR_W(ADDR_W), .COLL_CYC(COLL_CYC)) i_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .accel(accel), .ops_idle(ops_idle),
        .pg_req(pg_req), .er_add(er_add), .er_go(er_go), .er_chip(er_chip),
        .sus_req(sus_req), .res_req(res_req), .bypass_on(bypass_on));

    mbcs_track #(.IDX_W(IDX_W)) i_track (
        .clk(clk), .rst_n(rst_n), .pg_req(pg_req), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .er_add(er_add), .er_go(er_go), .er_chip(er_chip),
        .sus_req(sus_req), .res_req(res_req), .op_done(op_done),
        .bank_busy(bank_busy), .er_map(er_map), .er_susp(erase_susp),
        .ops_idle(ops_idle));

    // Read arbitration: array data only for idle banks outside suspended sectors.
    assign rd_array_ok = !bank_busy[rd_bank] && !(erase_susp && er_map[rd_idx]);
endmodule

// File: rtl/mbcs_chk.sv
// Property checker for mbcs_top, bound to every instance of it.
module mbcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       accel,
    input logic       op_done,
    input logic [3:0] bank_busy,
    input logic       rd_array_ok,
    input logic       bypass_on,
    input logic       erase_susp
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (bank_busy == 4'b0 && !erase_susp));

    assert_status_needs_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_array_ok |-> (bank_busy != 4'b0 || erase_susp));

    assert_bypass_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bypass_on) && !accel) |-> $past(wr_en && wr_data == 8'h20));

    assert_bypass_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_on) |-> $past(wr_en && wr_data == 8'h00));

    assert_accel_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accel |-> bypass_on);

    assert_busy_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bank_busy) & ~bank_busy) != 4'b0) |-> ($past(op_done) || $rose(erase_susp)));

    assert_suspend_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_susp) |-> $past(wr_en && wr_data == 8'hB0));

    assert_resume_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_susp) |-> $past(wr_en && wr_data == 8'h30));
endmodule

bind mbcs_top mbcs_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .accel(accel), .op_done(op_done), .bank_busy(bank_busy),
    .rd_array_ok(rd_array_ok), .bypass_on(bypass_on), .erase_susp(erase_susp));

// File: tb/test_mbcs_top.sv
// Bench for mbcs_top: directed sequences plus a seeded random phase of
// programs and completions during a suspended erase, against a bench model.
module test_mbcs_top;
    localparam int COLL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        accel = 1'b0;
    logic        op_done = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [3:0]  bank_busy;
    logic        rd_array_ok, bypass_on, erase_susp;

    int total = 0;
    int fails = 0;
    bit ended = 0;

    // Bench model for the random phase.
    bit        m_prog_on;
    int        m_prog_bank;
    bit        m_er_on, m_susp;
    bit [63:0] m_blk;

    always #2.5 clk = ~clk;

    mbcs_top #(.COLL_CYC(COLL)) i_mbcs_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .accel(accel), .op_done(op_done), .rd_addr(rd_addr),
        .bank_busy(bank_busy), .rd_array_ok(rd_array_ok),
        .bypass_on(bypass_on), .erase_susp(erase_susp));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unl();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    task automatic prog4(input logic [11:0] a);
        unl();
        wr(12'h555, 8'hA0);
        wr(a, 8'h5A);
    endtask

    task automatic erase_hdr();
        unl();
        wr(12'h555, 8'h80);
        unl();
    endtask

    task automatic done();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input bit exp);
        rd_addr = a;
        #1;
        chk(req, rd_array_ok, exp);
    endtask

    // Sector size from the geometry rule of R12.
    function automatic int sec_sz(input int a);
        return (a < 256 || a >= 3840) ? 64 : 256;
    endfunction

    function automatic void mark(input int a);
        int base = (a / sec_sz(a)) * sec_sz(a);
        for (int k = 0; k < sec_sz(a) / 64; k++) m_blk[base/64 + k] = 1'b1;
    endfunction

    function automatic bit m_busy(input int b);
        return (m_prog_on && m_prog_bank == b) ||
               (m_er_on && !m_susp && (m_blk[b*16 +: 16] != 16'h0));
    endfunction

    function automatic logic [3:0] m_busy_vec();
        logic [3:0] v;
        for (int b = 0; b < 4; b++) v[b] = m_busy(b);
        return v;
    endfunction

    function automatic bit m_rd(input int a);
        return !m_busy(a >> 10) && !(m_susp && m_blk[a >> 6]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            fails++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", bank_busy, 4'b0000);
        chk("R1 bypass", bypass_on, 0);
        chk("R1 susp", erase_susp, 0);
        rd_chk("R1 rd", 12'h000, 1);
        rd_chk("R1 rd", 12'hFFF, 1);

        // R2 four-write program in bank 2
        prog4(12'h9AB);
        chk("R2 busy", bank_busy, 4'b0100);
        rd_chk("R2 other bank rd", 12'h100, 1);
        rd_chk("R2 busy bank rd", 12'h9AB, 0);

        // R7 second program while one runs is ignored, done clears
        prog4(12'h400);
        chk("R7 second prog ignored", bank_busy, 4'b0100);
        done();
        chk("R7 done clears", bank_busy, 4'b0000);

        // R3 unlock mismatch
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h12);
        wr(12'h555, 8'hA0);
        wr(12'h400, 8'h33);
        chk("R3 mismatch", bank_busy, 4'b0000);

        // R4 bypass entry and two-write program
        unl();
        wr(12'h555, 8'h20);
        chk("R4 bypass on", bypass_on, 1);
        wr(12'h123, 8'hA0);
        wr(12'hC10, 8'h11);
        chk("R4 bypass prog", bank_busy, 4'b1000);
        done();

        // R5 bypass exit
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        chk("R5 bypass off", bypass_on, 0);
        wr(12'h000, 8'hA0);
        wr(12'hC10, 8'h11);
        chk("R5 short form dead", bank_busy, 4'b0000);

        // R6 accelerate input
        accel = 1'b1;
        #1;
        chk("R6 accel bypass", bypass_on, 1);
        @(negedge clk);
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        chk("R6 exit blocked", bypass_on, 1);
        wr(12'h000, 8'hA0);
        wr(12'h410, 8'h22);
        chk("R6 accel prog", bank_busy, 4'b0010);
        done();
        accel = 1'b0;
        @(negedge clk);
        chk("R6 bypass persists", bypass_on, 1);
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        chk("R6 exit after accel", bypass_on, 0);

        // R8 multi-sector erase with window expiry
        erase_hdr();
        wr(12'h000, 8'h30);
        wr(12'hE00, 8'h30);
        repeat (COLL - 1) @(negedge clk);
        chk("R8 collecting", bank_busy, 4'b0000);
        @(negedge clk);
        chk("R8 erase start", bank_busy, 4'b1001);

        // R13 erase refused while busy; zero-latency program elsewhere
        erase_hdr();
        wr(12'h555, 8'h10);
        chk("R13 refused", bank_busy, 4'b1001);
        prog4(12'h050);
        chk("R7 busy bank prog ignored", bank_busy, 4'b1001);
        prog4(12'h600);
        chk("R2 prog beside erase", bank_busy, 4'b1011);
        rd_chk("R2 idle bank rd", 12'h800, 1);
        rd_chk("R2 prog bank rd", 12'h600, 0);
        done();
        chk("R7 done ends program first", bank_busy, 4'b1001);

        // R10 suspend and R12 geometry
        wr(12'h000, 8'hB0);
        chk("R10 susp", erase_susp, 1);
        chk("R10 busy drops", bank_busy, 4'b0000);
        rd_chk("R10 erasing boot sector", 12'h010, 0);
        rd_chk("R12 next boot sector", 12'h040, 1);
        rd_chk("R10 erasing big sector", 12'hE10, 0);
        rd_chk("R10 same bank other sector", 12'hD00, 1);
        rd_chk("R12 top boot sector", 12'hF00, 1);
        prog4(12'h020);
        chk("R10 prog in erasing sector", bank_busy, 4'b0000);
        prog4(12'h0C0);
        chk("R10 prog outside sector", bank_busy, 4'b0001);
        done();

        // R10 random phase during suspend
        m_prog_on = 0; m_prog_bank = 0; m_er_on = 1; m_susp = 1; m_blk = '0;
        mark(12'h000);
        mark(12'hE00);
        for (int it = 0; it < 300; it++) begin
            int op;
            int a;
            op = int'($urandom % 4);
            a  = int'($urandom % 4096);
            if (op < 2) begin
                prog4(12'(a));
                if (!m_prog_on && !m_busy(a >> 10) && !(m_susp && m_blk[a >> 6])) begin
                    m_prog_on = 1; m_prog_bank = a >> 10;
                end
            end else if (op == 2) begin
                done();
                if (m_prog_on) m_prog_on = 0;
            end else begin
                @(negedge clk);
            end
            chk("R10 random busy", bank_busy, m_busy_vec());
            a = int'($urandom % 4096);
            rd_chk("R12 random rd", 12'(a), m_rd(a));
        end
        if (m_prog_on) done();

        // R11 resume then done
        wr(12'h000, 8'h30);
        chk("R11 resumed", erase_susp, 0);
        chk("R11 busy back", bank_busy, 4'b1001);
        done();
        chk("R11 erase ends", bank_busy, 4'b0000);

        // R9 chip erase
        erase_hdr();
        wr(12'h555, 8'h10);
        chk("R9 all busy", bank_busy, 4'b1111);
        rd_chk("R9 rd", 12'h7FF, 0);
        done();
        chk("R9 done", bank_busy, 4'b0000);

        // R8 collection ended by another write
        erase_hdr();
        wr(12'h500, 8'h30);
        wr(12'h000, 8'h00);
        chk("R8 early start", bank_busy, 4'b0010);
        done();
        chk("R8 done", bank_busy, 4'b0000);

        ended = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule